// File: doc/BRIEF.md
# Bidirectional Port with Pin Interrupts

This block is an 8-bit general-purpose I/O port that sits on a small microcontroller's byte bus. Software sets each pin as an input or an output through a direction register and drives output levels through a data register. Reading the data address returns a mix: output pins show what software wrote, and input pins show the level seen on the pad after a synchronizer.

Any pin can be chosen as an external interrupt source through a static option mask. When a pin is selected and is an input, its pull-up is switched on. The block combines the selected input pins with the synchronized main IRQ pin into one active-low line. A falling edge on that line sets a pending latch, which stays set until the CPU acknowledges the vector fetch. In edge-and-level mode the request is also held low for as long as the combined line is low. A small state machine sets and clears the latch. It has two states. ST_ARMED moves to ST_PENDING on a falling edge. ST_PENDING moves back to ST_ARMED on an acknowledge, but only if no new edge arrives in the same cycle. Because an output pin leaves the combine logic, its synchronized level only rejoins the line when the pin turns into an input. If that pin was driving 0, the latched low level produces a falling edge and an interrupt. Software avoids this by setting the data bit to 1 before it changes the direction.

Top module: `gpio_irq_port`

## Requirements
- R1: During reset and after it, every direction bit is 0: pin_oe = 0x00 and pin_pullup = 0x00, and a read of address 0x0005 returns 0x00. The request output irq_req_n is high.
- R2: A write to address 0x0005 loads the direction register, where a 1 makes that pin an output. pin_oe shows the new value in the cycle after the write, and a read of 0x0005 returns it.
- R3: A write to address 0x0001 loads the data register, and pin_out shows it in the cycle after the write. Reset does not change the data register.
- R4: A read of 0x0001 returns, for each bit, the data register bit when that pin is an output, and the pad level delayed by two clock edges when that pin is an input.
- R5: Address 0x3FF0 holds the interrupt option mask, which can be read and written and resets to 0x00. pin_pullup bit i is 1 exactly when option bit i is 1 and pin i is an input.
- R6: In edge mode (sense_level = 0), a falling edge on the AND of the synchronized IRQ pin and every option-enabled input pin drives irq_req_n low. Pins whose option bit is 0 and pins set as outputs have no effect on the request.
- R7: irq_req_n stays low until irq_ack is pulsed. After the acknowledge, in edge mode, the request stays high while the combined line stays low. A new request needs the line to go high and then fall again.
- R8: In edge-and-level mode (sense_level = 1), irq_req_n is low whenever the combined line is low, even after an acknowledge. It goes high once the line is high and the latch has been cleared.
- R9: Changing an option-enabled pin from output to input while its data bit is 0 raises an interrupt. Doing the same change with the data bit set to 1 does not.
- R10: Addresses other than 0x0001, 0x0005 and 0x3FF0 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| pin_pullup | output | 8 | Pad pull-up enables |
| irq_pin_n | input | 1 | Main IRQ pin, active low |
| sense_level | input | 1 | 0 selects edge mode, 1 selects edge-and-level mode |
| irq_ack | input | 1 | Interrupt vector fetch acknowledge |
| irq_req_n | output | 1 | Combined interrupt request, active low |

## Verification
The assertions take the following for granted. A write lasts one cycle with a stable address and data. irq_ack is a single-cycle pulse. pin_in is a clean digital level, and when a pin is an output, that level equals the pin's own output. The bench models the pad that way, changes inputs only on falling clock edges, and keeps each pin level for longer than the synchronizer depth before it samples. Whenever a test changes the option mask or direction in a way that could create a stray edge, the bench first gives the synchronizers time to settle, then clears any pending request with an acknowledge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Pending-latch controller states
    typedef enum logic [0:0] {
        ST_ARMED   = 1'b0,
        ST_PENDING = 1'b1
    } irq_state_e;

    // Register selected by the bus address
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_OPT  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = STAGES * W;

    logic [CHAIN_W-1:0] chain_q;

    // Shift register: the newest sample enters at the low end.
    // It resets to ones so that reset causes no falling edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[CHAIN_W-W-1:0], d};
        end
    end

    assign q = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int              W         = 8,
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0001,
    parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'h0005,
    parameter logic [ADDR_W-1:0] OPT_ADDR  = 16'h3FF0,
    parameter logic [W-1:0]    OPT_INIT  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_we,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      opt_q,
    output logic [W-1:0]      bus_rdata
);
    reg_sel_e sel;

    always_comb begin
        if (bus_addr == DATA_ADDR) begin
            sel = SEL_DATA;
        end else if (bus_addr == DIR_ADDR) begin
            sel = SEL_DIR;
        end else if (bus_addr == OPT_ADDR) begin
            sel = SEL_OPT;
        end else begin
            sel = SEL_NONE;
        end
    end

    // The data latch has no reset: its contents stay through reset
    always_ff @(posedge clk) begin
        if (bus_we && (sel == SEL_DATA)) begin
            data_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (bus_we && (sel == SEL_DIR)) begin
            dir_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q <= OPT_INIT;
        end else if (bus_we && (sel == SEL_OPT)) begin
            opt_q <= bus_wdata;
        end
    end

    // Output pins read back the latch, input pins read the synchronized pad
    always_comb begin
        unique case (sel)
            SEL_DATA: bus_rdata = (data_q & dir_q) | (pin_sync & ~dir_q);
            SEL_DIR:  bus_rdata = dir_q;
            SEL_OPT:  bus_rdata = opt_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] opt_q,
    input  logic         irq_sync,
    input  logic         sense_level,
    input  logic         irq_ack,
    output logic         comb_line,
    output logic         line_fall,
    output logic         pending,
    output logic         irq_req_n
);
    logic [W-1:0] src;
    logic         line_q;
    irq_state_e   state_q, state_d;

    // A pin counts only when it is enabled and set as an input.
    // Otherwise it holds its term of the AND high.
    for (genvar i = 0; i < W; i++) begin : g_src
        assign src[i] = pin_sync[i] | dir_q[i] | ~opt_q[i];
    end

    assign comb_line = (&src) & irq_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else begin
            line_q <= comb_line;
        end
    end

    assign line_fall = line_q & ~comb_line;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (line_fall) begin
                    state_d = ST_PENDING;
                end
            end
            ST_PENDING: begin
                if (irq_ack && !line_fall) begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // Output logic
    always_comb begin
        unique case (state_q)
            ST_PENDING: begin
                pending   = 1'b1;
                irq_req_n = 1'b0;
            end
            default: begin
                pending   = 1'b0;
                irq_req_n = ~(sense_level & ~comb_line);
            end
        endcase
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int                WIDTH       = 8,
    parameter int                ADDR_W      = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'h0001,
    parameter logic [ADDR_W-1:0] DIR_ADDR    = 16'h0005,
    parameter logic [ADDR_W-1:0] OPT_ADDR    = 16'h3FF0,
    parameter logic [WIDTH-1:0]  OPT_INIT    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_pullup,
    input  logic              irq_pin_n,
    input  logic              sense_level,
    input  logic              irq_ack,
    output logic              irq_req_n
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] data_q, dir_q, opt_q;
    logic             irq_sync;
    logic             comb_line, line_fall, irq_pending;

    gpio_pin_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_pin_sync #(.W(1), .STAGES(SYNC_STAGES)) u_irq_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_pin_n),
        .q     (irq_sync)
    );

    gpio_port_regs #(
        .W         (WIDTH),
        .ADDR_W    (ADDR_W),
        .DATA_ADDR (DATA_ADDR),
        .DIR_ADDR  (DIR_ADDR),
        .OPT_ADDR  (OPT_ADDR),
        .OPT_INIT  (OPT_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .pin_sync  (pin_sync),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .opt_q     (opt_q),
        .bus_rdata (bus_rdata)
    );

    gpio_irq_ctrl #(.W(WIDTH)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_sync    (pin_sync),
        .dir_q       (dir_q),
        .opt_q       (opt_q),
        .irq_sync    (irq_sync),
        .sense_level (sense_level),
        .irq_ack     (irq_ack),
        .comb_line   (comb_line),
        .line_fall   (line_fall),
        .pending     (irq_pending),
        .irq_req_n   (irq_req_n)
    );

    assign pin_out    = data_q;
    assign pin_oe     = dir_q;
    assign pin_pullup = opt_q & ~dir_q;

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int                WIDTH     = 8,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0001,
    parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'h0005,
    parameter logic [ADDR_W-1:0] OPT_ADDR  = 16'h3FF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic              bus_we,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_pullup,
    input logic              sense_level,
    input logic              irq_ack,
    input logic              irq_req_n,
    input logic              irq_pending,
    input logic              line_fall,
    input logic              comb_line
);
    logic unmapped;
    assign unmapped = (bus_addr != DATA_ADDR) && (bus_addr != DIR_ADDR) && (bus_addr != OPT_ADDR);

    AST_DIR_CLEARED_AT_RESET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (pin_oe == '0)); // R1
    AST_OE_FOLLOWS_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && bus_addr == DIR_ADDR) |=> (pin_oe == $past(bus_wdata))); // R2
    AST_OUT_FOLLOWS_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && bus_addr == DATA_ADDR) |=> (pin_out == $past(bus_wdata))); // R3
    AST_NO_PULLUP_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n) ((pin_pullup & pin_oe) == '0)); // R5
    AST_REQ_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n) irq_pending |-> !irq_req_n); // R6
    AST_EDGE_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!sense_level && !irq_pending) |-> irq_req_n); // R6
    AST_FALL_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n) line_fall |=> irq_pending); // R6
    AST_ACK_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n) (irq_pending && irq_ack && !line_fall) |=> !irq_pending); // R7
    AST_LEVEL_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (sense_level && !comb_line) |-> !irq_req_n); // R8
    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) unmapped |-> (bus_rdata == '0)); // R10

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
    .WIDTH     (WIDTH),
    .ADDR_W    (ADDR_W),
    .DATA_ADDR (DATA_ADDR),
    .DIR_ADDR  (DIR_ADDR),
    .OPT_ADDR  (OPT_ADDR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .bus_rdata   (bus_rdata),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .pin_pullup  (pin_pullup),
    .sense_level (sense_level),
    .irq_ack     (irq_ack),
    .irq_req_n   (irq_req_n),
    .irq_pending (irq_pending),
    .line_fall   (line_fall),
    .comb_line   (comb_line)
);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic [7:0]  pin_pullup;
    logic        irq_pin_n = 1'b1;
    logic        sense_level = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_req_n;

    // Pad model: outputs drive their own level. Inputs follow an external
    // driver when one is enabled, otherwise they float high.
    logic [7:0]  ext_en = 8'h00;
    logic [7:0]  ext_val = 8'h00;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ((ext_en & ext_val) | ~ext_en));

    gpio_irq_port dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_rdata   (bus_rdata),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .pin_pullup  (pin_pullup),
        .irq_pin_n   (irq_pin_n),
        .sense_level (sense_level),
        .irq_ack     (irq_ack),
        .irq_req_n   (irq_req_n)
    );

    // Vector: {requirement, address, write data, expected read-back}
    localparam logic [39:0] VEC [8] = '{
        {8'd2,  16'h0005, 8'hA5, 8'hA5},  // R2
        {8'd5,  16'h3FF0, 8'h3C, 8'h3C},  // R5
        {8'd2,  16'h0005, 8'hFF, 8'hFF},  // R2
        {8'd4,  16'h0001, 8'h5A, 8'h5A},  // R4 all outputs
        {8'd10, 16'h0100, 8'h00, 8'h00},  // R10
        {8'd10, 16'h3FF1, 8'h00, 8'h00},  // R10
        {8'd10, 16'h0004, 8'h00, 8'h00},  // R10
        {8'd5,  16'h3FF0, 8'h00, 8'h00}   // R5
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 16'h0000;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 16'h0000;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired, all requirements: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;

        // R1: reset state
        wait_cyc(3);
        check("R1 pin_oe in reset", pin_oe, 8'h00);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 pin_pullup after reset", pin_pullup, 8'h00);
        check("R1 irq_req_n after reset", {7'd0, irq_req_n}, 8'h01);
        bus_read(16'h0005, rd);
        check("R1 direction read after reset", rd, 8'h00);

        // Table of register write / read-back vectors
        for (int k = 0; k < 8; k++) begin
            bus_write(VEC[k][31:16], VEC[k][15:8]);
            bus_read(VEC[k][31:16], rd);
            checks++;
            if (rd !== VEC[k][7:0]) begin
                errors++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[k][39:32], k, rd, VEC[k][7:0]);
            end
        end

        // R10: unmapped writes left the registers alone
        bus_read(16'h0005, rd);
        check("R10 direction kept", rd, 8'hFF);
        bus_read(16'h0001, rd);
        check("R10 data kept", rd, 8'h5A);
        check("R3 pin_out follows data", pin_out, 8'h5A);

        // R3: reset keeps the data latch; R1 clears direction
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R3 pin_out kept through reset", pin_out, 8'h5A);
        check("R1 pin_oe cleared by reset", pin_oe, 8'h00);

        // R4: mixed read-back
        bus_write(16'h0005, 8'h0F);
        ext_en  = 8'hF0;
        ext_val = 8'h30;
        wait_cyc(3);
        bus_read(16'h0001, rd);
        check("R4 mixed read", rd, 8'h3A);
        ext_en = 8'h00;

        // R5: pull-up only on enabled inputs
        bus_write(16'h3FF0, 8'hF0);
        wait_cyc(1);
        check("R5 pullup F0 dir 0F", pin_pullup, 8'hF0);
        bus_write(16'h0005, 8'h3F);
        wait_cyc(1);
        check("R5 pullup F0 dir 3F", pin_pullup, 8'hC0);

        // Settle: clear options before changing direction
        bus_write(16'h3FF0, 8'h00);
        bus_write(16'h0005, 8'h00);
        wait_cyc(4);
        ack_pulse();
        wait_cyc(1);

        // R6 / R7: edge mode
        sense_level = 1'b0;
        bus_write(16'h3FF0, 8'h01);
        wait_cyc(4);
        check("R6 idle high", {7'd0, irq_req_n}, 8'h01);
        ext_en  = 8'h01;
        ext_val = 8'h00;
        wait_cyc(4);
        check("R6 enabled pin falls", {7'd0, irq_req_n}, 8'h00);
        wait_cyc(3);
        check("R7 still pending before ack", {7'd0, irq_req_n}, 8'h00);
        ack_pulse();
        wait_cyc(1);
        check("R7 ack clears while held low", {7'd0, irq_req_n}, 8'h01);
        wait_cyc(4);
        check("R7 no re-trigger while low", {7'd0, irq_req_n}, 8'h01);
        ext_en = 8'h00;
        wait_cyc(4);
        ext_en  = 8'h02;
        ext_val = 8'h00;
        wait_cyc(4);
        check("R6 disabled pin ignored", {7'd0, irq_req_n}, 8'h01);
        ext_en = 8'h00;
        irq_pin_n = 1'b0;
        wait_cyc(4);
        check("R6 IRQ pin falls", {7'd0, irq_req_n}, 8'h00);
        ack_pulse();
        irq_pin_n = 1'b1;
        wait_cyc(4);
        check("R7 cleared after ack", {7'd0, irq_req_n}, 8'h01);

        // R6 / R9: output pins and direction switching
        bus_write(16'h3FF0, 8'h04);
        bus_write(16'h0001, 8'h00);
        bus_write(16'h0005, 8'h04);
        wait_cyc(4);
        check("R6 output pin ignored", {7'd0, irq_req_n}, 8'h01);
        bus_write(16'h0005, 8'h00);
        wait_cyc(4);
        check("R9 switch with data 0 interrupts", {7'd0, irq_req_n}, 8'h00);
        ack_pulse();
        wait_cyc(4);
        check("R9 cleared", {7'd0, irq_req_n}, 8'h01);
        bus_write(16'h0005, 8'h04);
        bus_write(16'h0001, 8'h04);
        wait_cyc(4);
        bus_write(16'h0005, 8'h00);
        wait_cyc(4);
        check("R9 preset data 1 avoids interrupt", {7'd0, irq_req_n}, 8'h01);

        // R8: edge-and-level mode
        sense_level = 1'b1;
        bus_write(16'h3FF0, 8'h01);
        wait_cyc(4);
        check("R8 idle high", {7'd0, irq_req_n}, 8'h01);
        ext_en  = 8'h01;
        ext_val = 8'h00;
        wait_cyc(4);
        check("R8 low level requests", {7'd0, irq_req_n}, 8'h00);
        ack_pulse();
        wait_cyc(2);
        check("R8 held low after ack", {7'd0, irq_req_n}, 8'h00);
        ext_en = 8'h00;
        wait_cyc(4);
        check("R8 released", {7'd0, irq_req_n}, 8'h01);

        done = 1'b1;
        finish_run();
    end

endmodule